// File: doc/BRIEF.md
# Local Countdown Timer with Divider and Interrupt Pending Count

This block is a per-core countdown timer. Software programs it through a simple register write port: a start value, a clock-divide setting, a software-enable flag and a small set of vector entries. Entry 0 controls the timer itself. It selects one-shot or periodic operation, holds a mask and supplies the interrupt vector. The current count and every stored setting can be read back combinationally through a read-address port.

A prescaler turns the core clock into a slower count tick. The countdown register decrements once per tick. Each time it reaches zero it raises an expiry. Expiries are collected in a small saturating pending counter instead of a single flag, so none are lost while the consumer is busy. While the timer entry is unmasked and the count is non-zero, the block presents a request carrying the entry's vector. Each accepted request removes one expiry from the count.

Top module: `lt_timer`

## Requirements
- R1: The divide setting is the low 4 bits of the word written at address 1. Bit 2 is ignored. With s = {bit3,bit1,bit0} + 1 taken modulo 8, the count tick occurs once every 2^s clocks, so setting 0 gives divide by 2, 3 gives divide by 16 and 0xB gives divide by 1. The first tick arrives 2^s clocks after the start-value write.
- R2: A write to address 0 loads the start value into the current count, restarts the prescaler and clears the pending count. The current count is read at address 3.
- R3: A start value of 0 stops the timer. The current count then reads 0, and no expiry occurs.
- R4: In one-shot mode (entry 0 bit 17 clear), the count reaching zero produces one expiry, and the count then stays at 0 until the next start-value write.
- R5: In periodic mode (entry 0 bit 17 set), the count reloads the start value on each expiry. The pending count equals the number of expiries since the start write.
- R6: The request output is high when the pending count is non-zero and entry 0's mask (bit 16) is clear. The request vector is entry 0 bits 7:0. While the entry is masked, no request is raised and the accept input has no effect on the pending count.
- R7: An accepted request (accept input high while the request is high) lowers the pending count by one on that clock edge.
- R8: The pending count saturates at 2^PEND_W-1 and never wraps.
- R9: The software-enable flag is bit 8 of address 2. While the flag is clear, any write to entry i (address 8+i) stores its mask bit as 1.
- R10: Writing address 2 with bit 8 clear sets the mask bit of all entries and clears the pending count.
- R11: After reset, the start value, divide setting and enable flag are 0, every entry reads 0x00010000 (masked), the current count is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 start, 1 divide, 2 enable, 8+i entry i) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address (as write, plus 3 = current count) |
| rd_data | output | 32 | Read data, combinational |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector presented with the request |
| irq_ack | input | 1 | Request accepted this cycle |
| pend_cnt | output | PEND_W | Expiries not yet accepted |

## Verification
All eight divide encodings are swept against start values 1, 2, 3 and 5, in both one-shot and periodic mode. Bit 2 is toggled between the two modes. At every clock the bench predicts the current count and the pending count from floor(k/2^s). This catches a wrong divisor, an off-by-one first tick, a missing reload and a one-shot that fails to hold at zero. Directed sequences then cover the remaining cases: a zero start value, saturation, accepted and ignored acknowledgements, forced masking while disabled, and the enable-clear sweep. Each of these separates one priority or clear path from the normal count.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

    localparam int unsigned ADR_W = 4;

    localparam logic [ADR_W-1:0] ADR_START = 4'd0;
    localparam logic [ADR_W-1:0] ADR_DIV   = 4'd1;
    localparam logic [ADR_W-1:0] ADR_EN    = 4'd2;
    localparam logic [ADR_W-1:0] ADR_CUR   = 4'd3;
    localparam logic [ADR_W-1:0] ADR_ENT0  = 4'd8;

    localparam int unsigned EN_BIT   = 8;
    localparam int unsigned MASK_BIT = 16;
    localparam int unsigned PER_BIT  = 17;

    typedef struct packed {
        logic       masked;
        logic       periodic;
        logic [7:0] vec;
    } ent_t;

    // shift amount: ({b3,b1,b0} + 1) modulo 8
    function automatic logic [2:0] div_shift(input logic [2:0] sel);
        return sel + 3'd1;
    endfunction

    // divisor minus one, used as prescaler terminal value
    function automatic logic [7:0] div_last(input logic [2:0] sel);
        return (8'd1 << div_shift(sel)) - 8'd1;
    endfunction

    function automatic logic [31:0] ent_word(input ent_t e);
        return {14'd0, e.periodic, e.masked, 8'd0, e.vec};
    endfunction

endpackage

// File: rtl/lt_regs.sv
`timescale 1ns/1ps
module lt_regs
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_ENT = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADR_W-1:0]      wr_addr,
    input  logic [31:0]           wr_data,
    input  logic                  en_off,
    output logic [CNT_W-1:0]      start_val,
    output logic [3:0]            div_cfg,
    output logic                  sw_en,
    output ent_t [NUM_ENT-1:0]    ent
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_val <= '0;
            div_cfg   <= '0;
            sw_en     <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_START) start_val <= wr_data[CNT_W-1:0];
            if (wr_addr == ADR_DIV)   div_cfg   <= wr_data[3:0];
            if (wr_addr == ADR_EN)    sw_en     <= wr_data[EN_BIT];
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        localparam logic [ADR_W-1:0] MY_ADR = ADR_ENT0 + ADR_W'(g);
        ent_t r;
        logic hit;
        assign hit = wr_en && (wr_addr == MY_ADR);

        always_ff @(posedge clk) begin
            if (rst) begin
                r.masked   <= 1'b1;
                r.periodic <= 1'b0;
                r.vec      <= 8'd0;
            end else if (en_off) begin
                r.masked <= 1'b1;
            end else if (hit) begin
                r.masked   <= wr_data[MASK_BIT] | ~sw_en;
                r.periodic <= (g == 0) ? wr_data[PER_BIT] : 1'b0;
                r.vec      <= wr_data[7:0];
            end
        end
        assign ent[g] = r;

        // R9: disabled writes leave the entry masked
        assert_forced_mask_R9: assert property (@(posedge clk) disable iff (rst)
            (hit && !sw_en) |=> r.masked);
        // R10: enable clear masks every entry
        assert_mask_all_R10: assert property (@(posedge clk) disable iff (rst)
            en_off |=> r.masked);
    end

endmodule

// File: rtl/lt_prescaler.sv
`timescale 1ns/1ps
module lt_prescaler
    import lt_pkg::*;
#(
    parameter int unsigned PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [2:0] div_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre;
    logic [7:0]       last;

    assign last = div_last(div_sel);
    assign tick = ({{(8-PRE_W){1'b0}}, pre} >= last);

    always_ff @(posedge clk) begin
        if (rst || restart) pre <= '0;
        else if (tick)      pre <= '0;
        else                pre <= pre + 1'b1;
    end

    // R1: reaching the terminal value always wraps the prescaler
    assert_pre_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        ({{(8-PRE_W){1'b0}}, pre} >= last) |=> (pre == '0));

endmodule

// File: rtl/lt_countdown.sv
`timescale 1ns/1ps
module lt_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !load && (cur == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (tick && cur != '0) begin
            if (cur == ONE) cur <= periodic ? reload_val : '0;
            else            cur <= cur - ONE;
        end
    end

    // R2: a start write lands in the current count
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(load_val)));
    // R3/R4: a stopped or finished count stays at zero
    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cur == '0 && !load) |=> (cur == '0));

endmodule

// File: rtl/lt_pending.sv
`timescale 1ns/1ps
module lt_pending #(
    parameter int unsigned PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    input  logic              masked,
    input  logic              ack,
    output logic [PEND_W-1:0] cnt,
    output logic              req
);

    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    logic dec;
    assign req = (cnt != '0) && !masked;
    assign dec = req && ack;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != MAXV) cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8: saturated count never wraps
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && !clr && !dec) |=> (cnt == MAXV));
    // R7: accepted request removes exactly one expiry
    assert_accept_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !clr) |=> (cnt == $past(cnt) - 1'b1));
    // R10: clear empties the count
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/lt_timer.sv
`timescale 1ns/1ps
module lt_timer
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned PEND_W  = 4,
    parameter int unsigned NUM_ENT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_req,
    output logic [7:0]        irq_vec,
    input  logic              irq_ack,
    output logic [PEND_W-1:0] pend_cnt
);

    logic                 load, en_off, tick, expire, sw_en;
    logic [CNT_W-1:0]     start_val, cur;
    logic [3:0]           div_cfg;
    ent_t [NUM_ENT-1:0]   ent;

    assign load   = wr_en && (wr_addr == ADR_START);
    assign en_off = wr_en && (wr_addr == ADR_EN) && !wr_data[EN_BIT];

    lt_regs #(.CNT_W(CNT_W), .NUM_ENT(NUM_ENT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_off(en_off), .start_val(start_val),
        .div_cfg(div_cfg), .sw_en(sw_en), .ent(ent)
    );

    lt_prescaler #(.PRE_W(7)) u_pre (
        .clk(clk), .rst(rst), .restart(load),
        .div_sel({div_cfg[3], div_cfg[1], div_cfg[0]}), .tick(tick)
    );

    lt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(wr_data[CNT_W-1:0]),
        .reload_val(start_val), .periodic(ent[0].periodic), .tick(tick),
        .cur(cur), .expire(expire)
    );

    lt_pending #(.PEND_W(PEND_W)) u_pend (
        .clk(clk), .rst(rst), .clr(load || en_off), .inc(expire),
        .masked(ent[0].masked), .ack(irq_ack), .cnt(pend_cnt), .req(irq_req)
    );

    assign irq_vec = ent[0].vec;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_START) rd_data = 32'(start_val);
        if (rd_addr == ADR_DIV)   rd_data = 32'(div_cfg);
        if (rd_addr == ADR_EN)    rd_data = 32'(sw_en) << EN_BIT;
        if (rd_addr == ADR_CUR)   rd_data = 32'(cur);
        for (int i = 0; i < NUM_ENT; i++)
            if (rd_addr == ADR_ENT0 + ADR_W'(i)) rd_data = ent_word(ent[i]);
    end

    // R6: no request while the timer entry is masked, vector tracks the entry
    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (ent[0].masked && !load && !wr_en) |=> !irq_req || !ent[0].masked);

endmodule

// File: tb/sim_lt_timer.sv
`timescale 1ns/1ps
module sim_lt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic [3:0]  pend_cnt;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lt_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
        .pend_cnt(pend_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack_pulse;
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog all-R: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n_list[4];
        n_list = '{1, 2, 3, 5};

        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R11 reset state
        rd(4'd0, v); chk("R11 start", v, 32'h0);
        rd(4'd1, v); chk("R11 divide", v, 32'h0);
        rd(4'd2, v); chk("R11 enable", v, 32'h0);
        rd(4'd3, v); chk("R11 current", v, 32'h0);
        for (int e = 0; e < 6; e++) begin
            rd(4'(8 + e), v); chk("R11 entry masked", v, 32'h0001_0000);
        end
        chk("R11 req", {31'd0, irq_req}, 32'd0);
        chk("R11 pend", {28'd0, pend_cnt}, 32'd0);

        // R1 R2 R4 R5: sweep divide codes, start values, modes
        for (int code = 0; code < 8; code++) begin
            for (int ni = 0; ni < 4; ni++) begin
                for (int per = 0; per < 2; per++) begin
                    int n, d, lim;
                    logic [31:0] cfg;
                    n   = n_list[ni];
                    d   = 1 << ((code + 1) % 8);
                    lim = 2 * n * d + 1;
                    cfg = {28'd0, code[2], per[0], code[1], code[0]};
                    wr(4'd8, (per << 17) | 32'h0001_0000);
                    wr(4'd1, cfg);
                    wr(4'd0, 32'(n));
                    for (int k = 0; k <= lim; k++) begin
                        int t, ec, ep;
                        t = k / d;
                        if (per == 0) begin
                            ec = (t >= n) ? 0 : n - t;
                            ep = (t >= n) ? 1 : 0;
                        end else begin
                            ec = n - (t % n);
                            ep = t / n;
                        end
                        rd(4'd3, v);
                        chk(per ? "R5 R1 periodic count" : "R4 R1 one-shot count", v, 32'(ec));
                        chk(per ? "R5 periodic pending" : "R4 one-shot pending",
                            {28'd0, pend_cnt}, 32'(ep));
                        @(negedge clk);
                    end
                end
            end
        end

        // R2: restart clears pending
        wr(4'd1, 32'hB);
        wr(4'd8, 32'h0003_0000);
        wr(4'd0, 32'd2);
        wait_cyc(5);
        chk("R2 pending before restart", {28'd0, pend_cnt}, 32'd2);
        wr(4'd0, 32'd7);
        rd(4'd3, v); chk("R2 reload value", v, 32'd7);
        chk("R2 pending cleared", {28'd0, pend_cnt}, 32'd0);

        // R3: zero start stops the timer
        wr(4'd0, 32'd0);
        rd(4'd3, v); chk("R3 current zero", v, 32'd0);
        wait_cyc(12);
        rd(4'd3, v); chk("R3 stays zero", v, 32'd0);
        chk("R3 no expiry", {28'd0, pend_cnt}, 32'd0);

        // R8: saturation
        wr(4'd0, 32'd1);
        wait_cyc(30);
        chk("R8 saturate", {28'd0, pend_cnt}, 32'd15);
        chk("R6 masked no req", {31'd0, irq_req}, 32'd0);

        // R10: enable-clear sweeps masks and pending
        wr(4'd2, 32'h100);
        wr(4'd9, 32'h0000_0021);
        rd(4'd9, v); chk("R9 enabled unmasked write", v, 32'h0000_0021);
        wr(4'd2, 32'h0);
        chk("R10 pending cleared", {28'd0, pend_cnt}, 32'd0);
        for (int e = 0; e < 6; e++) begin
            rd(4'(8 + e), v);
            chk("R10 entry masked", {31'd0, v[16]}, 32'd1);
        end

        // R9: disabled write forced masked
        wr(4'd10, 32'h0000_0044);
        rd(4'd10, v); chk("R9 forced mask", v, 32'h0001_0044);

        // R6 R7: request, vector and accept
        wr(4'd2, 32'h100);
        wr(4'd8, 32'h0000_005A);
        wr(4'd0, 32'd2);
        chk("R6 no req yet", {31'd0, irq_req}, 32'd0);
        wait_cyc(2);
        chk("R6 pending one", {28'd0, pend_cnt}, 32'd1);
        chk("R6 req high", {31'd0, irq_req}, 32'd1);
        chk("R6 vector", {24'd0, irq_vec}, 32'h5A);
        ack_pulse();
        chk("R7 pending drained", {28'd0, pend_cnt}, 32'd0);
        chk("R7 req low", {31'd0, irq_req}, 32'd0);

        // R6: masked entry ignores accept
        wr(4'd8, 32'h0001_0033);
        wr(4'd0, 32'd1);
        wait_cyc(2);
        chk("R6 masked pending", {28'd0, pend_cnt}, 32'd1);
        chk("R6 masked req", {31'd0, irq_req}, 32'd0);
        ack_pulse();
        chk("R6 ack ignored", {28'd0, pend_cnt}, 32'd1);

        finish_run();
    end

endmodule